// File: doc/BRIEF.md
# Two-Level SMI Status Controller

This block gathers system-management interrupt requests from two places and drives a single SMI line toward the processor. One source is software: a write strobe to a dedicated trigger address raises an interrupt, and no data travels with the write. The other source is a general-purpose wake pin. A synchronizer watches the pin, and a change in either direction raises an interrupt. The pin counts only while it is configured as an input and its interrupt enable is set.

Status is kept at two levels. The pin event sets a second-level bit and a top-level summary bit. The software trigger sets its own top-level bit, so a handler can tell the two causes apart. Reading the second-level status address is destructive: it clears the pin bit and the summary bit in one step. A mirror address returns the same value and clears nothing, so the SMI stays up. A top-level address reports both top-level bits and clears only the software bit. The SMI output stays asserted while any status bit is set.

Top module: `smi_status_ctrl`

## Requirements
- R1: After reset, all status bits are 0, `smi_o` is 0, `top_sts` is 0 and every read returns 0.
- R2: A write strobe to the trigger address (default 0x10) sets the software status bit. This bit is `top_sts[1]`, and `smi_o` is 1 from the next cycle. A write to any other address changes nothing.
- R3: With `pin_is_out`=0 and `pin_smi_en`=1, a rising or a falling change on `wake_pin` sets the pin status bit and the summary bit (`top_sts[0]`). The change must be applied before clock edge k, and the bits are visible after edge k+2.
- R4: A pin change that reaches the detector while `pin_is_out`=1 or `pin_smi_en`=0 sets no status bit.
- R5: A read of the status address (default 0x14) returns the pin status in bit 2 and 0 in bits 7:3 and 1:0. From the next cycle it clears both the pin bit and the summary bit.
- R6: A read of the mirror address (default 0x18) returns the same value as the status address and clears nothing.
- R7: A read of the top-level address (default 0x1C) returns the software bit in bit 1, the summary bit in bit 0 and 0 elsewhere. It clears only the software bit.
- R8: `smi_o` is 1 exactly while any of the pin, summary or software bits is set. It falls in the cycle after the read that clears the last set bit.
- R9: A pin event that lands on the same edge as a clearing status read wins, and its bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_rdata | output | DATA_W | Read data, valid in the cycle `bus_rd` is high, otherwise 0 |
| wake_pin | input | 1 | Asynchronous wake pin |
| pin_is_out | input | 1 | Pin direction, 1 = output (pin events blocked) |
| pin_smi_en | input | 1 | Pin interrupt enable |
| smi_o | output | 1 | System-management interrupt request |
| top_sts | output | 2 | Top-level status: bit 1 software, bit 0 pin summary |

## Verification
The bench places a pin event on the same edge as a destructive read. A design that lets the clear win would lose the event and drop the SMI. It reads the mirror while status is pending. A design that clears on the mirror path would let `smi_o` fall too early. It also checks the exact edge on which a pin change first shows. An extra or a missing synchronizer stage would move that edge by one cycle. Pin changes made while the pin is set as an output or disabled are checked to leave no status. Random traffic mixes all addresses, pin toggles and gating changes, and a bench model checks every read word and every cycle of `smi_o` and `top_sts`.

// File: rtl/smi_status_ctrl.sv
module smi_status_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] A_TRIG = 8'h10,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h14,
  parameter logic [ADDR_W-1:0] A_MIRR = 8'h18,
  parameter logic [ADDR_W-1:0] A_TOP  = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake_pin,
  input  logic              pin_is_out,
  input  logic              pin_smi_en,
  output logic              smi_o,
  output logic [1:0]        top_sts
);
  localparam int PIN_BIT = 2;

  logic [SYNC_STAGES:0] sync_q;
  logic pin_sts, sum_sts, sw_sts;
  logic pin_ev, rd_stat, rd_top, wr_trig;
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], wake_pin};
  end

  assign pin_ev  = (sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES]) & ~pin_is_out & pin_smi_en;
  assign rd_stat = bus_rd && (bus_addr == A_STAT);
  assign rd_top  = bus_rd && (bus_addr == A_TOP);
  assign wr_trig = bus_wr && (bus_addr == A_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sts <= 1'b0;
      sum_sts <= 1'b0;
      sw_sts  <= 1'b0;
    end else begin
      pin_sts <= pin_ev | (pin_sts & ~rd_stat);
      sum_sts <= pin_ev | (sum_sts & ~rd_stat);
      sw_sts  <= wr_trig | (sw_sts & ~rd_top);
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr == A_STAT || bus_addr == A_MIRR) rd_word[PIN_BIT] = pin_sts;
    else if (bus_addr == A_TOP) rd_word[1:0] = {sw_sts, sum_sts};
  end

  assign bus_rdata = bus_rd ? rd_word : '0;
  assign top_sts   = {sw_sts, sum_sts};
  assign smi_o     = pin_sts | sum_sts | sw_sts;

  AST_TRIG_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TRIG) |=> (smi_o && top_sts[1])); // R2
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_is_out || !pin_smi_en) && !pin_sts) |=> !pin_sts); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT) |-> (bus_rdata[DATA_W-1:3] == '0 && bus_rdata[1:0] == 2'b00)); // R5
  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !pin_ev) |=> (!pin_sts && !top_sts[0])); // R5
  AST_MIRROR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_MIRR && pin_sts) |=> (pin_sts && smi_o)); // R6
  AST_SMI_FALL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smi_o) |-> $past(bus_rd)); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && pin_ev) |=> (pin_sts && top_sts[0])); // R9
endmodule

// File: tb/smi_status_ctrl_test.sv
module smi_status_ctrl_test;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_TRIG = 8'h10, A_STAT = 8'h14, A_MIRR = 8'h18, A_TOP = 8'h1C;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0, bus_rdata;
  logic wake_pin = 0, pin_is_out = 0, pin_smi_en = 1, smi_o;
  logic [1:0] top_sts;

  int total = 0, bad = 0;
  logic m_pin, m_sum, m_sw, ph1, ph2, ph3;

  smi_status_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .wake_pin(wake_pin),
    .pin_is_out(pin_is_out), .pin_smi_en(pin_smi_en), .smi_o(smi_o), .top_sts(top_sts));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [7:0] exp_stat();
    return {5'b0, m_pin, 2'b0};
  endfunction
  function automatic logic [7:0] exp_top();
    return {6'b0, m_sw, m_sum};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // op: 0 idle, 1 write trigger, 2 write status, 3 read status, 4 read mirror, 5 read top, 6 write mirror
  task automatic step(int op);
    logic ev;
    bus_wr = (op == 1 || op == 2 || op == 6);
    bus_rd = (op == 3 || op == 4 || op == 5);
    case (op)
      1: bus_addr = A_TRIG;
      2, 3: bus_addr = A_STAT;
      4, 6: bus_addr = A_MIRR;
      5: bus_addr = A_TOP;
      default: bus_addr = 8'h00;
    endcase
    #1;
    if (op == 3) chk("R5 status read", bus_rdata, exp_stat());
    if (op == 4) chk("R6 mirror read", bus_rdata, exp_stat());
    if (op == 5) chk("R7 top read", bus_rdata, exp_top());
    if (!bus_rd) chk("R1 idle rdata", bus_rdata, 0);
    @(posedge clk);
    ev = (ph2 ^ ph3) & ~pin_is_out & pin_smi_en;
    m_pin = ev | (m_pin & ~(op == 3));
    m_sum = ev | (m_sum & ~(op == 3));
    m_sw  = (op == 1) | (m_sw & ~(op == 5));
    ph3 = ph2; ph2 = ph1; ph1 = wake_pin;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk("R8 smi", smi_o, m_pin | m_sum | m_sw);
    chk("R7 top_sts", top_sts, {m_sw, m_sum});
  endtask

  initial begin
    void'($urandom(32'd2718));
    m_pin = 0; m_sum = 0; m_sw = 0; ph1 = 0; ph2 = 0; ph3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 smi after reset", smi_o, 0);
    chk("R1 top after reset", top_sts, 0);
    step(4);
    step(3);

    step(1);
    chk("R2 trigger raises smi", smi_o, 1);
    step(5);
    chk("R2 smi drops after top read", smi_o, 0);
    step(2); step(6);
    chk("R2 other writes no effect", smi_o, 0);

    pin_is_out = 1; wake_pin = 1;
    repeat (4) step(0);
    chk("R4 output pin blocked", smi_o, 0);
    pin_is_out = 0; pin_smi_en = 0; wake_pin = 0;
    repeat (4) step(0);
    chk("R4 disabled pin blocked", smi_o, 0);
    step(4);

    pin_smi_en = 1; wake_pin = 1;
    step(0); step(0);
    chk("R3 not yet after two edges", smi_o, 0);
    step(0);
    chk("R3 rising change seen", smi_o, 1);
    step(4);
    chk("R6 mirror keeps smi", smi_o, 1);
    step(3);
    chk("R5 status read clears", top_sts, 0);
    wake_pin = 0;
    repeat (3) step(0);
    chk("R3 falling change seen", top_sts, 2'b01);
    step(3);

    wake_pin = 1;
    step(0); step(0);
    step(3);
    chk("R9 event beats clear", smi_o, 1);
    step(4);
    step(3);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) wake_pin = ~wake_pin;
      if ($urandom_range(15) == 0) pin_is_out = $urandom_range(1);
      if ($urandom_range(15) == 0) pin_smi_en = $urandom_range(1);
      step($urandom_range(6));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule